// File: doc/BRIEF.md
# Serial LED Output Shifter

The block drives up to seventeen LED or GPIO outputs through an external serial-in, parallel-out shift register. It serialises a 17-bit vector most-significant bit first on a data line and a shift clock. It then gives a latch strobe, unless the external part is a plain shift register that has no storage stage. The shift-clock rate comes from a 2-bit divisor code. A programmable delay, with an internal limit, separates each data change from the rising clock edge that follows it.

Software writes a small register set. A data register holds the 17 output bits and shows a busy flag in bit 31 while a frame is being sent. A divisor register and a delay register set the timing. A mode register selects whether a latch strobe is given and whether pulse-width-modulated levels drive the outputs. In PWM mode the serial bits come from a 17-bit vector of generator levels supplied by a neighbouring generator bank. A new frame starts whenever that vector changes to a value that is not all zeros. A vector of all zeros never causes a frame, so software clears the external register with an all-zero frame in data mode before it turns PWM mode on.

Top module: `serial_led_shifter`

## Requirements
- R1: Reading `data_rd` returns the busy flag in bit 31, the last accepted data value in bits [16:0] and zeros in bits [30:17]. The busy flag is 1 from the clock edge that accepts a frame start until the edge that ends the frame.
- R2: A write to the data register (`reg_addr` 0) or to the mode register (`reg_addr` 3) has no effect while the busy flag is set.
- R3: Each frame sends all 17 bits most-significant first, one bit per period of 4, 8, 16 or 32 system clocks for divisor codes 0, 1, 2 and 3. `sr_dat` is sampled on the rising edge of `sr_clk`.
- R4: Within each bit period `sr_dat` changes at the start of the period, and `sr_clk` rises delay+1 system clocks later, where delay is the effective delay value. `sr_clk` then stays high for half the period, and `sr_dat` does not change while `sr_clk` is high.
- R5: A programmed delay value above divisor/2−1 is treated as divisor/2−1.
- R6: When mode bit 0 is clear, a latch strobe follows the 17th bit. `sr_latch` is high for one bit period with `sr_clk` low, so the frame lasts 18 bit periods. When mode bit 0 is set, no strobe is given and the frame lasts 17 bit periods.
- R7: When mode bit 1 is set and the block is idle, a frame of `pwm_levels` starts at the next clock edge if the vector has at least one bit set and differs from the last vector sent. An unchanged vector starts no new frame.
- R8: In PWM mode an all-zero `pwm_levels` vector starts no frame.
- R9: After reset, and whenever the block is idle, `sr_clk`, `sr_dat` and `sr_latch` are 0. Reset clears the data, divisor, delay and mode registers.
- R10: The divisor register (`reg_addr` 1, bits [1:0]) and the delay register (`reg_addr` 2, bits [3:0]) accept writes at any time. A frame uses the values held when it starts. A data write accepted in the same cycle as a PWM start takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 divisor, 2 delay, 3 mode |
| reg_wdata | input | 17 | Register write data |
| pwm_levels | input | 17 | Per-output levels from the generator bank |
| data_rd | output | 32 | Data register readback with busy flag in bit 31 |
| sr_clk | output | 1 | Shift clock to the external register |
| sr_dat | output | 1 | Serial data to the external register |
| sr_latch | output | 1 | Storage latch strobe |

## Verification
The hardest situation to reach is a mode write that arrives during a frame while the generator levels already hold a vector that would start a PWM frame. If the write were wrongly accepted, the bench would see an extra frame after the current one ends. The stimulus sends a data-mode frame, raises the levels and writes PWM mode while busy is still set. It then waits well past the frame end and requires that no frame arrives. The all-zero PWM case is reached in the same way: software first sends a zero frame in data mode, then enables PWM mode with zero levels and checks that the block stays idle.

// File: rtl/sled_pkg.sv
package sled_pkg;

    localparam int NOUT  = 17;
    localparam int RDW   = 32;
    localparam int DIVW  = 2;
    localparam int DLYW  = 4;
    localparam int MAXDIV = 4 << ((1 << DIVW) - 1);
    localparam int PHW   = $clog2(MAXDIV);
    localparam int CNTW  = PHW + 1;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_DIV  = 2'd1,
        A_DLY  = 2'd2,
        A_MODE = 2'd3
    } sled_addr_e;

    typedef struct packed {
        logic pwm_en;
        logic no_latch;
    } sled_mode_t;

    typedef struct packed {
        logic [DIVW-1:0] div;
        logic [DLYW-1:0] dly;
        logic            latch;
    } sled_frame_cfg_t;

    function automatic logic [CNTW-1:0] div_len(input logic [DIVW-1:0] code);
        return CNTW'(4) << code;
    endfunction

    function automatic logic [DLYW-1:0] dly_clamp(input logic [DIVW-1:0] code,
                                                   input logic [DLYW-1:0] d);
        logic [CNTW-1:0] lim;
        lim = (div_len(code) >> 1) - CNTW'(1);
        return (CNTW'(d) > lim) ? DLYW'(lim) : d;
    endfunction

endpackage

// File: rtl/sled_regs.sv
module sled_regs
    import sled_pkg::*;
#(
    parameter int N = NOUT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [N-1:0]    reg_wdata,
    input  logic            busy,
    output logic [N-1:0]    data_q,
    output logic [DIVW-1:0] div_q,
    output logic [DLYW-1:0] dly_q,
    output sled_mode_t      mode_q,
    output logic            data_start
);
    sled_addr_e addr;
    logic       accept;

    assign addr       = sled_addr_e'(reg_addr);
    assign accept     = reg_wr && !busy;
    assign data_start = accept && (addr == A_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            div_q  <= '0;
            dly_q  <= '0;
            mode_q <= '0;
        end else begin
            if (data_start)
                data_q <= reg_wdata;
            if (reg_wr && addr == A_DIV)
                div_q <= reg_wdata[DIVW-1:0];
            if (reg_wr && addr == A_DLY)
                dly_q <= reg_wdata[DLYW-1:0];
            if (accept && addr == A_MODE)
                mode_q <= sled_mode_t'(reg_wdata[1:0]);
        end
    end
endmodule

// File: rtl/sled_trigger.sv
module sled_trigger
    import sled_pkg::*;
#(
    parameter int N = NOUT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm_en,
    input  logic         busy,
    input  logic         data_start,
    input  logic [N-1:0] data_new,
    input  logic [N-1:0] pwm_levels,
    output logic         start,
    output logic [N-1:0] start_bits
);
    logic [N-1:0] last_q;
    logic         pwm_go;

    assign pwm_go     = pwm_en && !busy && !data_start &&
                        (|pwm_levels) && (pwm_levels != last_q);
    assign start      = data_start || pwm_go;
    assign start_bits = data_start ? data_new : pwm_levels;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (start)
            last_q <= start_bits;
    end
endmodule

// File: rtl/sled_seq.sv
module sled_seq
    import sled_pkg::*;
#(
    parameter int N = NOUT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [N-1:0]    start_bits,
    input  logic [DIVW-1:0] div_code,
    input  logic [DLYW-1:0] dly,
    input  logic            no_latch,
    output logic            busy,
    output logic            sr_clk,
    output logic            sr_dat,
    output logic            sr_latch
);
    localparam int IDXW = $clog2(N + 1);

    sled_frame_cfg_t  cfg_q;
    logic             busy_q;
    logic [PHW-1:0]   phase_q;
    logic [IDXW-1:0]  idx_q;
    logic [N-1:0]     sh_q;

    logic             last_phase;
    logic             last_idx;
    logic             in_latch;
    logic [CNTW:0]    ph_x;
    logic [CNTW:0]    dl_x;
    logic [CNTW:0]    hi_end;

    assign last_phase = (CNTW'(phase_q) == div_len(cfg_q.div) - CNTW'(1));
    assign last_idx   = cfg_q.latch ? (idx_q == IDXW'(N)) : (idx_q == IDXW'(N - 1));
    assign in_latch   = (idx_q == IDXW'(N));

    assign ph_x   = (CNTW+1)'(phase_q);
    assign dl_x   = (CNTW+1)'(cfg_q.dly);
    assign hi_end = dl_x + (CNTW+1)'(div_len(cfg_q.div) >> 1);

    assign busy     = busy_q;
    assign sr_clk   = busy_q && !in_latch && (ph_x > dl_x) && (ph_x <= hi_end);
    assign sr_dat   = busy_q && !in_latch && sh_q[N-1];
    assign sr_latch = busy_q && in_latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            cfg_q   <= '0;
        end else if (start && !busy_q) begin
            busy_q     <= 1'b1;
            phase_q    <= '0;
            idx_q      <= '0;
            sh_q       <= start_bits;
            cfg_q.div  <= div_code;
            cfg_q.dly  <= dly_clamp(div_code, dly);
            cfg_q.latch <= !no_latch;
        end else if (busy_q) begin
            if (last_phase) begin
                phase_q <= '0;
                if (last_idx) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + IDXW'(1);
                    sh_q  <= {sh_q[N-2:0], 1'b0};
                end
            end else begin
                phase_q <= phase_q + PHW'(1);
            end
        end
    end
endmodule

// File: rtl/serial_led_shifter.sv
module serial_led_shifter
    import sled_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [NOUT-1:0]  reg_wdata,
    input  logic [NOUT-1:0]  pwm_levels,
    output logic [RDW-1:0]   data_rd,
    output logic             sr_clk,
    output logic             sr_dat,
    output logic             sr_latch
);
    logic [NOUT-1:0] data_q;
    logic [DIVW-1:0] div_q;
    logic [DLYW-1:0] dly_q;
    sled_mode_t      mode_q;
    logic            data_start;
    logic            busy;
    logic            start;
    logic [NOUT-1:0] start_bits;
    logic            mode_pwm;

    assign mode_pwm = mode_q.pwm_en;
    assign data_rd  = {busy, {(RDW-NOUT-1){1'b0}}, data_q};

    sled_regs #(.N(NOUT)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .data_q(data_q), .div_q(div_q),
        .dly_q(dly_q), .mode_q(mode_q), .data_start(data_start)
    );

    sled_trigger #(.N(NOUT)) u_trig (
        .clk(clk), .rst(rst), .pwm_en(mode_pwm), .busy(busy),
        .data_start(data_start), .data_new(reg_wdata), .pwm_levels(pwm_levels),
        .start(start), .start_bits(start_bits)
    );

    sled_seq #(.N(NOUT)) u_seq (
        .clk(clk), .rst(rst), .start(start), .start_bits(start_bits),
        .div_code(div_q), .dly(dly_q), .no_latch(mode_q.no_latch),
        .busy(busy), .sr_clk(sr_clk), .sr_dat(sr_dat), .sr_latch(sr_latch)
    );
endmodule

// File: rtl/sled_checker.sv
module sled_checker
    import sled_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            sr_clk,
    input logic            sr_dat,
    input logic            sr_latch,
    input logic            reg_wr,
    input logic [1:0]      reg_addr,
    input logic [NOUT-1:0] data_q,
    input logic            mode_pwm,
    input logic [NOUT-1:0] pwm_levels
);
    // R2: data write during a frame leaves the data register unchanged
    a_r2_data_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == 2'd0) |=> $stable(data_q));

    // R2: mode write during a frame leaves the mode unchanged
    a_r2_mode_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == 2'd3) |=> $stable(mode_pwm));

    // R4: serial data is stable while the shift clock is high
    a_r4_dat_stable: assert property (@(posedge clk) disable iff (rst)
        (sr_clk && $past(sr_clk)) |-> (sr_dat == $past(sr_dat)));

    // R6: the latch strobe never overlaps a shift clock pulse
    a_r6_latch_no_clk: assert property (@(posedge clk) disable iff (rst)
        sr_latch |-> !sr_clk);

    // R8: an all-zero vector in PWM mode starts no frame
    a_r8_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && mode_pwm && pwm_levels == '0 && !reg_wr) |=> !busy);

    // R9: outputs are quiet when no frame is running
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sr_clk && !sr_dat && !sr_latch));
endmodule

bind serial_led_shifter sled_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .sr_clk(sr_clk), .sr_dat(sr_dat),
    .sr_latch(sr_latch), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .data_q(data_q), .mode_pwm(mode_pwm), .pwm_levels(pwm_levels)
);

// File: tb/serial_led_shifter_bench.sv
module serial_led_shifter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [16:0] reg_wdata = '0;
    logic [16:0] pwm_levels = '0;
    logic [31:0] data_rd;
    logic        sr_clk, sr_dat, sr_latch;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [16:0] bits;
        bit          latch;
        int          len;
        int          rise;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    serial_led_shifter u_serial_led_shifter (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pwm_levels(pwm_levels), .data_rd(data_rd),
        .sr_clk(sr_clk), .sr_dat(sr_dat), .sr_latch(sr_latch)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [16:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_expect(input logic [16:0] bits, input bit latch,
                               input int div, input int dly, input string tag);
        exp_t e;
        int lim;
        lim = (2 << div) - 1;
        e.bits  = bits;
        e.latch = latch;
        e.len   = (4 << div) * (latch ? 18 : 17);
        e.rise  = ((dly > lim) ? lim : dly) + 1;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (data_rd[31] && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_busy();
        int guard = 0;
        while (!data_rd[31] && guard < 100) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Monitor: rebuilds each frame from the pins and compares with the queue
    initial begin
        bit pb = 0, pc = 0, b;
        int cnt = 0, rise = -1;
        logic [16:0] got = '0;
        bit lat = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                b = data_rd[31];
                if (b && !pb) begin
                    cnt = 0; got = '0; lat = 0; rise = -1;
                end
                if (b) begin
                    if (sr_clk && !pc) begin
                        got = {got[15:0], sr_dat};
                        if (rise < 0) rise = cnt;
                    end
                    if (sr_latch) lat = 1;
                    cnt++;
                end
                if (!b && pb) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2/R7/R8", "unexpected frame", got, 0);
                    end else begin
                        e = exp_q.pop_front();
                        check(got == e.bits, {e.tag, " R3"}, "frame bits", got, e.bits);
                        check(lat == e.latch, {e.tag, " R6"}, "latch strobe", lat, e.latch);
                        check(cnt == e.len, {e.tag, " R3/R6"}, "frame length", cnt, e.len);
                        check(rise == e.rise, {e.tag, " R4/R5"}, "first clock rise", rise, e.rise);
                    end
                end
                pb = b; pc = sr_clk;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(data_rd == 32'h0, "R9", "data_rd after reset", data_rd, 0);
        check({sr_clk, sr_dat, sr_latch} == 3'b000, "R9", "pins after reset",
              {sr_clk, sr_dat, sr_latch}, 0);

        // R3 R1: divide-by-4, latch, delay 0
        wr(2'd1, 17'd0); wr(2'd2, 17'd0); wr(2'd3, 17'd0);
        push_expect(17'h1A5A5, 1, 0, 0, "R1 div4");
        wr(2'd0, 17'h1A5A5);
        check(data_rd[31] == 1'b1, "R1", "busy after write", data_rd[31], 1);
        check(data_rd[30:0] == 31'h1A5A5, "R1", "readback bits", data_rd[30:0], 17'h1A5A5);
        // R2: data write while busy ignored
        wr(2'd0, 17'h00001);
        check(data_rd[16:0] == 17'h1A5A5, "R2", "data held during frame",
              data_rd[16:0], 17'h1A5A5);
        wait_idle();
        check(data_rd[31] == 1'b0, "R1", "busy cleared after frame", data_rd[31], 0);

        // R3 R4: divide-by-16 with delay 3
        wr(2'd1, 17'd2); wr(2'd2, 17'd3);
        push_expect(17'h0F00F, 1, 2, 3, "R4 div16");
        wr(2'd0, 17'h0F00F);
        // R10: timing write during frame takes effect at next frame
        wr(2'd1, 17'd3); wr(2'd2, 17'd9);
        wait_idle();

        // R3: divide-by-32 with delay 9
        push_expect(17'h10001, 1, 3, 9, "R10 div32");
        wr(2'd0, 17'h10001);
        wait_idle();

        // R5: divide-by-8 with delay 15 clamps to 3
        wr(2'd1, 17'd1); wr(2'd2, 17'd15);
        push_expect(17'h15555, 1, 1, 15, "R5 clamp div8");
        wr(2'd0, 17'h15555);
        wait_idle();

        // R5: divide-by-4 with delay 5 clamps to 1
        wr(2'd1, 17'd0); wr(2'd2, 17'd5);
        push_expect(17'h0AAAA, 1, 0, 5, "R5 clamp div4");
        wr(2'd0, 17'h0AAAA);
        wait_idle();

        // R6: no latch strobe when mode bit 0 is set
        wr(2'd2, 17'd0); wr(2'd3, 17'd1);
        push_expect(17'h1FFFF, 0, 0, 0, "R6 nolatch");
        wr(2'd0, 17'h1FFFF);
        wait_idle();

        // R8: zero frame in data mode, then PWM with zero levels stays idle
        wr(2'd3, 17'd0);
        push_expect(17'h00000, 1, 0, 0, "R8 clear");
        wr(2'd0, 17'h00000);
        wait_idle();
        pwm_levels = '0;
        wr(2'd3, 17'd2);
        repeat (100) @(negedge clk);
        check(data_rd[31] == 1'b0, "R8", "idle with zero levels", data_rd[31], 0);

        // R7: a new nonzero vector starts a frame
        push_expect(17'h10001, 1, 0, 0, "R7 pwm a");
        pwm_levels = 17'h10001;
        @(negedge clk);
        wait_busy();
        wait_idle();
        repeat (150) @(negedge clk);
        check(data_rd[31] == 1'b0, "R7", "no retrigger on same vector", data_rd[31], 0);
        push_expect(17'h00003, 1, 0, 0, "R7 pwm b");
        pwm_levels = 17'h00003;
        @(negedge clk);
        wait_busy();
        wait_idle();
        // R8: dropping to zero starts nothing
        pwm_levels = '0;
        repeat (150) @(negedge clk);
        check(data_rd[31] == 1'b0, "R8", "no frame on zero vector", data_rd[31], 0);

        // R2: mode write during a frame is ignored
        wr(2'd3, 17'd0);
        push_expect(17'h00F0F, 1, 0, 0, "R2 mode lock");
        wr(2'd0, 17'h00F0F);
        pwm_levels = 17'h1FFFF;
        wr(2'd3, 17'd2);
        wait_idle();
        repeat (150) @(negedge clk);
        check(data_rd[31] == 1'b0, "R2", "mode write while busy ignored", data_rd[31], 0);

        check(exp_q.size() == 0, "R7", "all expected frames seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule